// File: doc/BRIEF.md
# Compare-Triggered Pattern Output Unit

This unit drives a 16-bit parallel output port built from four 4-bit groups. Group 0 covers bits 3..0, group 1 bits 7..4, group 2 bits 11..8 and group 3 bits 15..12. Software preloads a next-pattern register and a per-bit enable mask. When the compare-match strobe chosen for a group fires, every enabled bit of that group copies its next-pattern bit onto the port. Disabled bits keep their value.

Each group picks one of four compare-match inputs through a 2-bit field in the control register. When groups 3 and 2 pick the same input, their next-pattern bits share one byte address. When they pick different inputs, each of the two groups has its own byte address, and the unused half of each of those bytes reads back as ones. A standby input freezes the unit and keeps all of its contents.

An 8-bit register bus with a 3-bit address gives access to the output, enable, next-pattern and control registers. Read data is registered.

Top module: `pattern_out_unit`

## Requirements
- R1: While `rst` is high, the output port, the enable mask, the next-pattern bits, the control register and `bus_rdata` all clear to zero. With control at zero, groups 3 and 2 use the shared layout.
- R2: When the compare-match input selected for a group is high at a clock edge and `standby` is low, the enabled bits of that group take their next-pattern bits at that edge.
- R3: Output bits whose enable bit is clear are never changed by a compare match.
- R4: Control bits [2g+1:2g] hold the index (0..3) of the compare-match input for group g. A pulse on an input that a group does not select leaves that group unchanged.
- R5: Register map: address 0 = output bits 7..0, 1 = output bits 15..8, 2 = enable bits 7..0, 3 = enable bits 15..8, 4 = next-pattern bits 7..0, 7 = control. All are read/write.
- R6: With the shared layout (control[7:6] == control[5:4]), address 5 holds next-pattern bits 15..8, with group 3 in data bits 7..4 and group 2 in bits 3..0. Address 6 reads 0x00 and ignores writes.
- R7: With the split layout (control[7:6] != control[5:4]), address 5 holds group 3 in data bits 7..4, and its bits 3..0 read as 0xF and ignore writes. Address 6 holds group 2 in data bits 3..0, and its bits 7..4 read as 0xF and ignore writes.
- R8: When a compare match and a bus write to an output register fall in the same cycle, the enabled bits of the firing groups take the next pattern. All other bits of the written byte take the written data.
- R9: While `standby` is high, compare matches and bus writes have no effect, and every register keeps its contents.
- R10: `bus_rdata` presents the register addressed in cycle t after the clock edge that ends cycle t, reflecting the register contents before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Freeze request; all state is retained |
| cm_pulse | input | 4 | Single-cycle compare-match strobes |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pattern_out | output | 16 | Parallel pattern output port |

## Verification
The assertions assume that every input is a known value at each clock edge once reset has been released. They also assume that compare-match strobes are synchronous to `clk`, so a pulse seen at an edge belongs to that edge alone. The stimulus meets these assumptions by driving all inputs on the falling edge from a single process. Pulses last exactly one cycle in the directed phases. In the random phase, any pattern of strobes may appear, including several at once, together with bus writes and standby.

// File: rtl/pou_pkg.sv
`timescale 1ns/1ps
package pou_pkg;
  localparam int GRP_W   = 4;
  localparam int NUM_GRP = 4;
  localparam int PORT_W  = GRP_W * NUM_GRP;
  localparam int NUM_CM  = 4;
  localparam int SEL_W   = $clog2(NUM_CM);
  localparam int CTRL_W  = SEL_W * NUM_GRP;
  localparam int BUS_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int GPB     = BUS_W / GRP_W;

  localparam logic [ADDR_W-1:0] ADR_OUT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_OUT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_EN_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_EN_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ND_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_ND_HI  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_ND_G2  = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd7;
endpackage

// File: rtl/pou_trig_select.sv
`timescale 1ns/1ps
module pou_trig_select #(
  parameter int NUM_GRP = 4,
  parameter int NUM_CM  = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_CM-1:0]        cm,
  input  logic [NUM_GRP*SEL_W-1:0] sel,
  output logic [NUM_GRP-1:0]       fire
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_sel
    assign fire[g] = cm[sel[g*SEL_W +: SEL_W]];
  end
endmodule

// File: rtl/pou_group.sv
`timescale 1ns/1ps
module pou_group #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         fire,
  input  logic         nd_we,
  input  logic         en_we,
  input  logic         out_we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] nd_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] out_q
);
  logic [W-1:0] load_mask;
  logic [W-1:0] base_val;

  assign load_mask = fire ? en_q : '0;
  assign base_val  = out_we ? wd : out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nd_q  <= '0;
      en_q  <= '0;
      out_q <= '0;
    end else if (!hold) begin
      if (nd_we) nd_q <= wd;
      if (en_we) en_q <= wd;
      out_q <= (nd_q & load_mask) | (base_val & ~load_mask);
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (nd_q == '0 && en_q == '0 && out_q == '0));

  assert_load_enabled_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && !hold) |=> (((out_q ^ $past(nd_q)) & $past(en_q)) == '0));

  assert_keep_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    !out_we |=> (((out_q ^ $past(out_q)) & ~$past(en_q)) == '0));

  assert_write_rest_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && out_we && !hold) |=> (((out_q ^ $past(wd)) & ~$past(en_q)) == '0));

  assert_standby_keep_R9: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(nd_q) && $stable(en_q) && $stable(out_q)));
endmodule

// File: rtl/pou_bus_if.sv
`timescale 1ns/1ps
module pou_bus_if
  import pou_pkg::*;
(
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PORT_W-1:0] out_all,
  input  logic [PORT_W-1:0] en_all,
  input  logic [PORT_W-1:0] nd_all,
  input  logic [CTRL_W-1:0] sel,
  output logic              shared,
  output logic [NUM_GRP-1:0] out_we,
  output logic [NUM_GRP-1:0] en_we,
  output logic [NUM_GRP-1:0] nd_we,
  output logic              ctrl_we,
  output logic [BUS_W-1:0]  rd_next
);
  localparam logic [GRP_W-1:0] ONES = '1;

  assign shared  = (sel[3*SEL_W +: SEL_W] == sel[2*SEL_W +: SEL_W]);
  assign ctrl_we = we && (addr == ADR_CTRL);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
    localparam int B = g / GPB;
    assign out_we[g] = we && (addr == ADR_OUT_LO + ADDR_W'(B));
    assign en_we[g]  = we && (addr == ADR_EN_LO + ADDR_W'(B));
    if (g < GPB) begin : g_lo
      assign nd_we[g] = we && (addr == ADR_ND_LO);
    end else if (g == 3) begin : g_three
      assign nd_we[g] = we && (addr == ADR_ND_HI);
    end else begin : g_two
      assign nd_we[g] = we && (addr == (shared ? ADR_ND_HI : ADR_ND_G2));
    end
  end

  always_comb begin
    case (addr)
      ADR_OUT_LO: rd_next = out_all[BUS_W-1:0];
      ADR_OUT_HI: rd_next = out_all[PORT_W-1:BUS_W];
      ADR_EN_LO:  rd_next = en_all[BUS_W-1:0];
      ADR_EN_HI:  rd_next = en_all[PORT_W-1:BUS_W];
      ADR_ND_LO:  rd_next = nd_all[BUS_W-1:0];
      ADR_ND_HI:  rd_next = shared ? nd_all[PORT_W-1:BUS_W]
                                   : {nd_all[3*GRP_W +: GRP_W], ONES};
      ADR_ND_G2:  rd_next = shared ? '0 : {ONES, nd_all[2*GRP_W +: GRP_W]};
      default:    rd_next = sel;
    endcase
  end
endmodule

// File: rtl/pattern_out_unit.sv
`timescale 1ns/1ps
module pattern_out_unit
  import pou_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic [NUM_CM-1:0] cm_pulse,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [PORT_W-1:0] pattern_out
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic [NUM_GRP-1:0] fire, out_we, en_we, nd_we;
  logic [PORT_W-1:0]  en_all, nd_all, out_all;
  logic               shared, ctrl_we;
  logic [BUS_W-1:0]   rd_next;

  pou_trig_select #(.NUM_GRP(NUM_GRP), .NUM_CM(NUM_CM), .SEL_W(SEL_W)) u_trig (
    .cm(cm_pulse), .sel(ctrl_q), .fire(fire));

  pou_bus_if u_bus (
    .we(bus_we), .addr(bus_addr), .out_all(out_all), .en_all(en_all),
    .nd_all(nd_all), .sel(ctrl_q), .shared(shared), .out_we(out_we),
    .en_we(en_we), .nd_we(nd_we), .ctrl_we(ctrl_we), .rd_next(rd_next));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    pou_group #(.W(GRP_W)) u_grp (
      .clk(clk), .rst(rst), .hold(standby), .fire(fire[g]),
      .nd_we(nd_we[g]), .en_we(en_we[g]), .out_we(out_we[g]),
      .wd(bus_wdata[(g % GPB)*GRP_W +: GRP_W]),
      .nd_q(nd_all[g*GRP_W +: GRP_W]),
      .en_q(en_all[g*GRP_W +: GRP_W]),
      .out_q(out_all[g*GRP_W +: GRP_W]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (ctrl_we && !standby) ctrl_q <= bus_wdata[CTRL_W-1:0];
      bus_rdata <= rd_next;
    end
  end

  assign pattern_out = out_all;

  assert_fire_needs_cm_R4: assert property (@(posedge clk) disable iff (rst)
    (fire != '0) |-> (cm_pulse != '0));

  assert_shared_g2_blank_R6: assert property (@(posedge clk) disable iff (rst)
    (shared && bus_addr == ADR_ND_G2) |=> (bus_rdata == '0));

  assert_split_reserved_R7: assert property (@(posedge clk) disable iff (rst)
    (!shared && bus_addr == ADR_ND_HI) |=> (bus_rdata[GRP_W-1:0] == '1));

  assert_ctrl_standby_R9: assert property (@(posedge clk) disable iff (rst)
    standby |=> $stable(ctrl_q));
endmodule

// File: tb/pattern_out_unit_tb.sv
`timescale 1ns/1ps
module pattern_out_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby = 1'b0;
  logic [3:0]  cm_pulse = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] pattern_out;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [15:0] m_out, m_en, m_nd;
  logic [7:0]  m_sel, e_rd;

  pattern_out_unit u_dut (
    .clk(clk), .rst(rst), .standby(standby), .cm_pulse(cm_pulse),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pattern_out(pattern_out));

  always #2 clk = ~clk;

  function automatic logic [7:0] read_model(input logic [2:0] a);
    bit sh = (m_sel[7:6] == m_sel[5:4]);
    case (a)
      3'd0: return m_out[7:0];
      3'd1: return m_out[15:8];
      3'd2: return m_en[7:0];
      3'd3: return m_en[15:8];
      3'd4: return m_nd[7:0];
      3'd5: return sh ? m_nd[15:8] : {m_nd[15:12], 4'hF};
      3'd6: return sh ? 8'h00 : {4'hF, m_nd[11:8]};
      default: return m_sel;
    endcase
  endfunction

  task automatic model_edge();
    logic [15:0] mask, nxt;
    bit sh;
    e_rd = rst ? 8'h00 : read_model(bus_addr);
    if (rst) begin
      m_out = '0; m_en = '0; m_nd = '0; m_sel = '0;
    end else if (!standby) begin
      sh = (m_sel[7:6] == m_sel[5:4]);
      mask = '0;
      for (int g = 0; g < 4; g++)
        if (cm_pulse[m_sel[2*g +: 2]]) mask[4*g +: 4] = 4'hF;
      mask &= m_en;
      nxt = m_out;
      if (bus_we && bus_addr == 3'd0) nxt[7:0] = bus_wdata;
      if (bus_we && bus_addr == 3'd1) nxt[15:8] = bus_wdata;
      nxt = (nxt & ~mask) | (m_nd & mask);
      if (bus_we) begin
        case (bus_addr)
          3'd2: m_en[7:0] = bus_wdata;
          3'd3: m_en[15:8] = bus_wdata;
          3'd4: m_nd[7:0] = bus_wdata;
          3'd5: if (sh) m_nd[15:8] = bus_wdata; else m_nd[15:12] = bus_wdata[7:4];
          3'd6: if (!sh) m_nd[11:8] = bus_wdata[3:0];
          3'd7: m_sel = bus_wdata;
          default: ;
        endcase
      end
      m_out = nxt;
    end
  endtask

  task automatic chk(input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, "pattern_out", pattern_out, m_out);
    chk(tag, "bus_rdata", {8'h00, bus_rdata}, {8'h00, e_rd});
  endtask

  task automatic cyc(input string tag, input logic [2:0] a, input logic we,
                     input logic [7:0] wd, input logic [3:0] cm);
    bus_addr = a; bus_we = we; bus_wdata = wd; cm_pulse = cm;
    step(tag);
    bus_we = 1'b0; cm_pulse = '0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    cyc(tag, a, 1'b0, 8'h00, 4'h0);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [7:0] wd);
    cyc(tag, a, 1'b1, wd, 4'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_out = '0; m_en = '0; m_nd = '0; m_sel = '0; e_rd = '0;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) step("R1");
    rst = 1'b0;
    for (int a = 0; a < 8; a++) rd("R1", 3'(a));

    // R5: register map read/write
    wr("R5", 3'd2, 8'hFF); wr("R5", 3'd3, 8'hFF);
    wr("R5", 3'd4, 8'hA5); wr("R5", 3'd5, 8'h3C);
    wr("R5", 3'd0, 8'h12); wr("R5", 3'd1, 8'h34);
    for (int a = 0; a < 8; a++) rd("R5", 3'(a));

    // R2: all groups on input 0
    cyc("R2", 3'd0, 1'b0, 8'h00, 4'b0001);
    rd("R2", 3'd0); rd("R2", 3'd1);
    cyc("R2", 3'd0, 1'b0, 8'h00, 4'b0010);

    // R3: partial enable
    wr("R3", 3'd2, 8'h0F); wr("R3", 3'd3, 8'hC3);
    wr("R3", 3'd4, 8'h5A); wr("R3", 3'd5, 8'h96);
    cyc("R3", 3'd0, 1'b0, 8'h00, 4'b0001);
    rd("R3", 3'd0); rd("R3", 3'd1);

    // R4: distinct selects, g0=1 g1=2 g2=3 g3=3 (shared)
    wr("R4", 3'd7, 8'hF9);
    wr("R4", 3'd2, 8'hFF); wr("R4", 3'd3, 8'hFF);
    wr("R4", 3'd4, 8'hE7); wr("R4", 3'd5, 8'h18);
    cyc("R4", 3'd0, 1'b0, 8'h00, 4'b0001);
    cyc("R4", 3'd0, 1'b0, 8'h00, 4'b0010);
    cyc("R4", 3'd0, 1'b0, 8'h00, 4'b0100);
    cyc("R4", 3'd1, 1'b0, 8'h00, 4'b1000);

    // R6: shared layout
    wr("R6", 3'd5, 8'h81); wr("R6", 3'd6, 8'h77);
    rd("R6", 3'd5); rd("R6", 3'd6);
    cyc("R6", 3'd1, 1'b0, 8'h00, 4'b1000);

    // R7: split layout, g3=2
    wr("R7", 3'd7, 8'hB9);
    rd("R7", 3'd5); rd("R7", 3'd6);
    wr("R7", 3'd5, 8'h9C); wr("R7", 3'd6, 8'hE4);
    rd("R7", 3'd5); rd("R7", 3'd6);
    cyc("R7", 3'd1, 1'b0, 8'h00, 4'b0100);
    cyc("R7", 3'd1, 1'b0, 8'h00, 4'b1000);

    // R8: trigger and output write in the same cycle
    wr("R8", 3'd3, 8'h0F); wr("R8", 3'd5, 8'h50); wr("R8", 3'd6, 8'h0A);
    cyc("R8", 3'd1, 1'b1, 8'h6C, 4'b1000);
    rd("R8", 3'd1);
    cyc("R8", 3'd1, 1'b1, 8'hF0, 4'b1100);
    rd("R8", 3'd1);

    // R9: standby freezes everything
    standby = 1'b1;
    wr("R9", 3'd2, 8'h00); wr("R9", 3'd7, 8'h00); wr("R9", 3'd4, 8'h11);
    cyc("R9", 3'd0, 1'b1, 8'h99, 4'b1111);
    rd("R9", 3'd2); rd("R9", 3'd7);
    standby = 1'b0;
    rd("R9", 3'd2); rd("R9", 3'd0);

    // R10: random traffic, read data checked every cycle
    for (int i = 0; i < 3000; i++) begin
      standby = ($urandom_range(0, 15) == 0);
      cyc("R10", 3'($urandom_range(0, 7)), 1'($urandom_range(0, 2) == 0),
          8'($urandom), 4'($urandom));
    end
    standby = 1'b0;
    rst = 1'b1;
    step("R1");
    rst = 1'b0;
    rd("R1", 3'd3);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule